// File: doc/BRIEF.md
# LIN Controller Error Flag Register

This block holds the sticky error flags of a LIN/UART controller in one 8-bit register. The receive and transmit engines drive single-cycle error pulses into it. Each error class has its own enable input, and a pulse only latches into its flag while that enable is high. Software reads the flags back at any time and has no side effects by reading. It clears chosen flags with one 8-bit write that carries 0 in each bit to clear and 1 in every bit to keep.

A mode input tells the block when the controller sits in its reset mode. In that mode the register is forced to zero. Bus writes and error pulses are both ignored until the mode is left. The timeout flag merges two sources, a frame timeout and a response timeout, under one enable. Bit 1 is reserved.

Top module: `lin_err_status`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) `rd_data` reads 8'h00.
- R2: With `in_reset_mode` low, a pulse on `err_pulse[i]` while `err_en[i]` is 1 sets flag i at the next edge. The flag positions are fixed for software: bit 7 response-preparation error, bit 6 ID parity error, bit 5 checksum error, bit 4 sync-field error, bit 3 framing error, bit 2 timeout, bit 0 bit error.
- R3: A pulse whose enable bit is 0 leaves its flag unchanged.
- R4: The timeout flag (bit 2) sets from a frame timeout on `err_pulse[2]` or from a response timeout on `resp_timeout`, in both cases only while `err_en[2]` is 1.
- R5: Bit 1 always reads 0. Pulses and writes aimed at bit 1 do not change it.
- R6: A write with `wr_en` high clears, at the next edge, every flag whose `wr_data` bit is 0. Flags whose `wr_data` bit is 1 keep their value.
- R7: If a flag is set by an enabled pulse and cleared by a write in the same cycle, the flag ends up 1.
- R8: While `in_reset_mode` is high, the register becomes 8'h00 at the next edge and stays 8'h00. Writes and error pulses in that mode have no effect.
- R9: With no pulse, no write and no mode change, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_reset_mode | input | 1 | Controller is in reset mode: clear and lock the register |
| err_pulse | input | 8 | Error pulses, one per flag position; bit 2 is the frame timeout, bit 1 unused |
| resp_timeout | input | 1 | Response timeout pulse, merged into bit 2 |
| err_en | input | 8 | Detection enable per flag position; bit 1 unused |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Write data; 0 bits clear, 1 bits keep |
| rd_data | output | 8 | Current flag values |

## Verification
On every cycle, the assertions check that the reserved bit reads zero and that reset mode empties the register. They also check that an enabled pulse beats a same-cycle clear, that a 0 write bit empties a flag, that all-ones writes keep flags, and that idle cycles hold the value. The bench's scenarios are needed to show that each error class lands in its own bit position. They also show that the response timeout reaches the timeout bit, that disabled classes stay silent while others latch, and that the register comes back usable after leaving reset mode.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;
  localparam int ERR_W  = 8;
  localparam int B_BIT  = 0;
  localparam int B_RSVD = 1;
  localparam int B_TMO  = 2;
  localparam int B_FRM  = 3;
  localparam int B_SYNC = 4;
  localparam int B_CKS  = 5;
  localparam int B_IDP  = 6;
  localparam int B_PREP = 7;
  // bits that hold a real flag
  localparam logic [ERR_W-1:0] LIVE_MASK = ~(ERR_W'(1) << B_RSVD);
endpackage

// File: rtl/lin_err_gate.sv
module lin_err_gate
  import lin_err_pkg::*;
#(
  parameter int W = ERR_W
) (
  input  logic         lock,
  input  logic [W-1:0] pulse,
  input  logic         resp_to,
  input  logic [W-1:0] en,
  output logic [W-1:0] set_vec
);
  always_comb begin
    set_vec = pulse & en & W'(LIVE_MASK);
    // timeout flag merges frame and response timeouts
    set_vec[B_TMO] = (pulse[B_TMO] | resp_to) & en[B_TMO];
    if (lock) set_vec = '0;
  end
endmodule

// File: rtl/lin_err_clr.sv
module lin_err_clr
  import lin_err_pkg::*;
#(
  parameter int W = ERR_W
) (
  input  logic         lock,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] clr_vec
);
  always_comb begin
    clr_vec = '0;
    if (wr_en && !lock) clr_vec = ~wr_data & W'(LIVE_MASK);
  end
endmodule

// File: rtl/lin_err_cell.sv
module lin_err_cell (
  input  logic clk,
  input  logic rst,
  input  logic hold_zero,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || hold_zero) q <= 1'b0;
    else if (set_i)       q <= 1'b1;   // set beats clear
    else if (clr_i)       q <= 1'b0;
  end
endmodule

// File: rtl/lin_err_status.sv
module lin_err_status
  import lin_err_pkg::*;
#(
  parameter int W = ERR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_reset_mode,
  input  logic [W-1:0] err_pulse,
  input  logic         resp_timeout,
  input  logic [W-1:0] err_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] flags;

  lin_err_gate #(.W(W)) u_gate (
    .lock    (in_reset_mode),
    .pulse   (err_pulse),
    .resp_to (resp_timeout),
    .en      (err_en),
    .set_vec (set_vec)
  );

  lin_err_clr #(.W(W)) u_clr (
    .lock    (in_reset_mode),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clr_vec (clr_vec)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE_MASK[i]) begin : g_live
      lin_err_cell u_cell (
        .clk       (clk),
        .rst       (rst),
        .hold_zero (in_reset_mode),
        .set_i     (set_vec[i]),
        .clr_i     (clr_vec[i]),
        .q         (flags[i])
      );
    end else begin : g_rsvd
      assign flags[i] = 1'b0;
    end
  end

  assign rd_data = flags;
endmodule

// File: rtl/lin_err_status_chk.sv
module lin_err_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_reset_mode,
  input logic [7:0] err_pulse,
  input logic       resp_timeout,
  input logic [7:0] err_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> rd_data == 8'h00); // R1
  AST_BIT0_SETS: assert property (@(posedge clk) disable iff (rst)
    (!in_reset_mode && err_pulse[0] && err_en[0] && !wr_en) |=> rd_data[0]); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!in_reset_mode && !err_en[3] && !rd_data[3]) |=> !rd_data[3]); // R3
  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!in_reset_mode && (err_pulse & err_en) == 8'h00 && !resp_timeout && rd_data == 8'h00)
      |=> rd_data == 8'h00); // R3
  AST_RESP_TMO: assert property (@(posedge clk) disable iff (rst)
    (!in_reset_mode && resp_timeout && err_en[2]) |=> rd_data[2]); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_data[1]); // R5
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!in_reset_mode && wr_en && !wr_data[0] && !(err_pulse[0] && err_en[0])) |=> !rd_data[0]); // R6
  AST_ONES_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!in_reset_mode && wr_en && wr_data == 8'hFF && rd_data[7]) |=> rd_data[7]); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (!in_reset_mode && wr_en && !wr_data[5] && err_pulse[5] && err_en[5]) |=> rd_data[5]); // R7
  AST_MODE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    in_reset_mode |=> rd_data == 8'h00); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_reset_mode && !wr_en && err_pulse == 8'h00 && !resp_timeout) |=> $stable(rd_data)); // R9
endmodule

bind lin_err_status lin_err_status_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_reset_mode (in_reset_mode),
  .err_pulse     (err_pulse),
  .resp_timeout  (resp_timeout),
  .err_en        (err_en),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_data       (rd_data)
);

// File: tb/lin_err_status_test.sv
module lin_err_status_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_reset_mode = 1'b0;
  logic [7:0] err_pulse = 8'h00;
  logic       resp_timeout = 1'b0;
  logic [7:0] err_en = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lin_err_status uut (
    .clk(clk), .rst(rst), .in_reset_mode(in_reset_mode),
    .err_pulse(err_pulse), .resp_timeout(resp_timeout), .err_en(err_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  // {mode, wr_en, wr_data, err_pulse, resp_timeout, err_en, expected rd_data}
  localparam int NV = 23;
  localparam logic [34:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,8'h00,8'h01,1'b0,8'hFF,8'h01},
    {1'b0,1'b0,8'h00,8'h80,1'b0,8'hFF,8'h81},
    {1'b0,1'b0,8'h00,8'h40,1'b0,8'hFF,8'hC1},
    {1'b0,1'b0,8'h00,8'h20,1'b0,8'hFF,8'hE1},
    {1'b0,1'b0,8'h00,8'h10,1'b0,8'hFF,8'hF1},
    {1'b0,1'b0,8'h00,8'h08,1'b0,8'hFF,8'hF9},
    {1'b0,1'b0,8'h00,8'h04,1'b0,8'hFF,8'hFD},
    {1'b0,1'b0,8'h00,8'h02,1'b0,8'hFF,8'hFD},
    {1'b0,1'b1,8'hFF,8'h00,1'b0,8'hFF,8'hFD},
    {1'b0,1'b1,8'h7F,8'h00,1'b0,8'hFF,8'h7D},
    {1'b0,1'b1,8'hFE,8'h00,1'b0,8'hFF,8'h7C},
    {1'b0,1'b1,8'h00,8'h00,1'b0,8'hFF,8'h00},
    {1'b0,1'b1,8'hFF,8'h00,1'b0,8'hFF,8'h00},
    {1'b0,1'b0,8'h00,8'hFD,1'b0,8'h00,8'h00},
    {1'b0,1'b0,8'h00,8'h00,1'b1,8'h04,8'h04},
    {1'b0,1'b1,8'h00,8'h04,1'b0,8'hFF,8'h04},
    {1'b0,1'b1,8'h00,8'h00,1'b0,8'hFF,8'h00},
    {1'b0,1'b0,8'h00,8'hFF,1'b0,8'hF7,8'hF5},
    {1'b0,1'b0,8'h00,8'h00,1'b0,8'hFF,8'hF5},
    {1'b1,1'b0,8'h00,8'h00,1'b0,8'hFF,8'h00},
    {1'b1,1'b0,8'h00,8'hFF,1'b1,8'hFF,8'h00},
    {1'b1,1'b1,8'hFF,8'h00,1'b0,8'hFF,8'h00},
    {1'b0,1'b0,8'h00,8'h01,1'b0,8'hFF,8'h01}
  };

  function automatic string tag_of(int i);
    if (i <= 6)  return "R2";
    if (i == 7)  return "R5";
    if (i <= 12) return (i == 12) ? "R5" : "R6";
    if (i == 13) return "R3";
    if (i == 14) return "R4";
    if (i == 15) return "R7";
    if (i == 16) return "R6";
    if (i == 17) return "R3";
    if (i == 18) return "R9";
    if (i <= 21) return "R8";
    return "R2";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    in_reset_mode = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    err_pulse = 8'h00; resp_timeout = 1'b0; err_en = 8'hFF;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: rd_data=%h expected completion", rd_data);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", rd_data, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {in_reset_mode, wr_en, wr_data, err_pulse, resp_timeout, err_en} = VEC[i][34:8];
      @(negedge clk);
      check(tag_of(i), rd_data, VEC[i][7:0]);
    end
    idle();

    // R9: several idle cycles keep the flags
    repeat (3) @(negedge clk);
    check("R9", rd_data, 8'h01);

    // R1: reset mid-run empties the register
    err_pulse = 8'hF0;
    @(negedge clk);
    check("R2", rd_data, 8'hF1);
    err_pulse = 8'h00;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", rd_data, 8'h00);

    // R8: entering reset mode while a write and pulse are active
    err_pulse = 8'h0C;
    @(negedge clk);
    check("R2", rd_data, 8'h0C);
    in_reset_mode = 1'b1; wr_en = 1'b1; wr_data = 8'hFF; err_pulse = 8'h80;
    @(negedge clk);
    check("R8", rd_data, 8'h00);
    idle();
    @(negedge clk);
    check("R8", rd_data, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule